// File: doc/BRIEF.md
# Overflow-Derandomizing Event Counter for a Two-Dimensional Detector

This block sits in front of a slow processor and takes a stream of events from a two-dimensional position sensitive detector. Each event is a linear pixel address. The detector marks an event with a falling edge on an active-low strobe. The block keeps one narrow wrap-around counter per pixel. Every event adds one to the addressed counter. Only when a counter rolls over does the block produce output: it writes that pixel's address into a queue. Each queued address therefore stands for a fixed number of counts (eight with the default 3-bit counters). A bursty, random event stream becomes a sparse, ordered stream of overflow addresses.

Two equal queue banks take the overflow addresses. Only one bank collects at any time. When the collecting bank fills, hardware turns it over to the processor, starts collecting in the other bank and raises a full flag. The processor acknowledges by resetting its read index, which clears the flag. It then empties the bank through a drain port. Each drain read returns one entry, zeroes it and steps the index.

If the next fill arrives before that acknowledgment, a sticky overrun flag is set. From then on, overflow addresses are dropped. When acquisition stops, the processor reads out the residual counter values, which are cleared as they are read, and empties both banks to finish its totals.

Top module: `ovf_derand_counter`

## Requirements
- R1: After reset, or after a cycle with cmd_init high, the block clears every counter and every entry of both banks. The clearing sweep lasts max(2^AW, DEPTH) cycles, which is 256 with the defaults, and evt_ack stays low for the whole sweep. After the sweep, buf_full, overrun and fill_level are 0. act_bank is 0 after reset and takes the value of init_bank after cmd_init.
- R2: An event is accepted when a clock edge sees evt_strobe_n low after it was high at the previous edge, and evt_ack is high. On acceptance the block latches evt_addr and adds one, modulo 2^CW, to that pixel's counter. evt_ack is low from the next cycle until the event is finished.
- R3: A falling edge of evt_strobe_n seen while evt_ack is low has no effect on any counter.
- R4: An increment that takes a counter from all ones (7) back to 0 pushes the latched address into the collecting bank, at the position given by fill_level. fill_level then rises by one.
- R5: Suppose a push raises fill_level to DEPTH while buf_full is clear, or while it is being cleared in that same cycle. Then act_bank toggles, fill_level restarts at 0 for the new collecting bank, and buf_full is set.
- R6: Suppose the same filling push happens while buf_full is still set. The entry is stored, overrun is set, and act_bank and fill_level do not change. Later overflow addresses are dropped, but the counters keep counting. overrun clears only by reset or cmd_init.
- R7: drain_rd returns, in the next cycle with drain_valid high, the entry at the read index of the bank chosen by drain_bank. It writes 0 into that entry and advances the index modulo DEPTH. The index is shared by both banks.
- R8: cmd_drain_rst sets the read index to 0 and clears buf_full. A drain_rd in the same cycle is ignored: no drain_valid follows.
- R9: A cnt_rd is accepted in a cycle where evt_ack is high and no event is accepted. The counter at cnt_rd_addr is returned on cnt_data in the next cycle, with cnt_valid high, and is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the clearing sweep |
| cmd_init | input | 1 | One-cycle command: clear everything and set the collecting bank |
| init_bank | input | 1 | Collecting bank selected by cmd_init |
| evt_strobe_n | input | 1 | Active-low event strobe; a falling edge marks an event |
| evt_addr | input | AW | Linear pixel address of the event |
| evt_ack | output | 1 | High when the block can take a new event |
| cnt_rd | input | 1 | Counter readback request (read and clear) |
| cnt_rd_addr | input | AW | Counter to read back |
| cnt_data | output | CW | Counter value read back |
| cnt_valid | output | 1 | cnt_data holds the result of a readback |
| drain_rd | input | 1 | Drain read request (read, clear, advance) |
| drain_bank | input | 1 | Bank read by drain_rd |
| cmd_drain_rst | input | 1 | Reset the drain index and clear buf_full |
| drain_data | output | AW | Drained overflow address |
| drain_valid | output | 1 | drain_data holds the result of a drain read |
| act_bank | output | 1 | Bank currently collecting overflow addresses |
| fill_level | output | $clog2(DEPTH)+1 | Entries pushed into the collecting bank |
| buf_full | output | 1 | A filled bank is waiting for acknowledgment |
| overrun | output | 1 | Sticky: a fill arrived before the previous bank was acknowledged |

## Verification
The assertions check the following on every cycle:
- the strobe handshake: acknowledge drops after an accepted edge;
- buf_full can rise only together with a bank swap;
- an overrun never moves the collecting bank, and the overrun flag is sticky;
- every drain or readback request is answered one cycle later;
- fill_level never exceeds DEPTH.

Only the bench scenarios can show whether the right pixel was counted and the right address was queued and drained in order. The same holds for clear-on-read, for edges ignored while busy, and for the exact sweep length and state after a clear. All of these come from comparing the ports against a model built from randomized event streams.

// File: rtl/ovf_derand_pkg.sv
package ovf_derand_pkg;

    typedef enum logic [2:0] {
        ST_SWEEP,
        ST_IDLE,
        ST_READ,
        ST_UPD,
        ST_PUSH
    } seq_state_e;

    typedef struct packed {
        logic ovr;
        logic full;
    } derand_flags_t;

    function automatic int sweep_span(input int aw, input int depth);
        int ncnt;
        ncnt = 1 << aw;
        return (ncnt > depth) ? ncnt : depth;
    endfunction

endpackage

// File: rtl/ovf_strobe_edge.sv
module ovf_strobe_edge (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n,
    output logic fall
);
    logic strobe_q;

    always_ff @(posedge clk) begin
        if (rst) strobe_q <= 1'b1;
        else     strobe_q <= strobe_n;
    end

    assign fall = strobe_q & ~strobe_n;
endmodule

// File: rtl/ovf_cnt_array.sv
module ovf_cnt_array #(
    parameter int AW = 8,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic [AW-1:0] rd_addr,
    output logic [CW-1:0] rd_data,
    input  logic          we,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] wr_data
);
    localparam int NCNT = 1 << AW;

    logic [CW-1:0] mem [NCNT];

    // registered, read-first port: a read and a write to the same word
    // in one cycle return the old value
    always_ff @(posedge clk) begin
        rd_data <= mem[rd_addr];
        if (we) mem[wr_addr] <= wr_data;
    end
endmodule

// File: rtl/ovf_fifo_bank.sv
module ovf_fifo_bank #(
    parameter int DW = 4,
    parameter int EW = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_idx,
    input  logic [EW-1:0] wr_data,
    input  logic          clr_en,
    input  logic [DW-1:0] clr_idx,
    output logic [EW-1:0] rd_data
);
    localparam int NENT = 1 << DW;

    logic [EW-1:0] mem [NENT];

    // a drain reads the old word and zeroes it in one cycle; a push to the
    // same slot in that cycle wins over the zero
    always_ff @(posedge clk) begin
        if (clr_en) begin
            rd_data      <= mem[clr_idx];
            mem[clr_idx] <= '0;
        end
        if (wr_en) mem[wr_idx] <= wr_data;
    end
endmodule

// File: rtl/ovf_derand_ctrl.sv
module ovf_derand_ctrl
    import ovf_derand_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DEPTH = 16,
    parameter int CW    = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cmd_init,
    input  logic                     init_bank,
    input  logic                     evt_fall,
    input  logic [AW-1:0]            evt_addr,
    output logic                     evt_ack,
    input  logic                     cnt_rd,
    input  logic [AW-1:0]            cnt_rd_addr,
    input  logic [CW-1:0]            cnt_q,
    output logic [AW-1:0]            cnt_raddr,
    output logic                     cnt_we,
    output logic [AW-1:0]            cnt_waddr,
    output logic [CW-1:0]            cnt_wdata,
    output logic                     cnt_valid,
    input  logic                     drain_rd,
    input  logic                     drain_bank,
    input  logic                     cmd_drain_rst,
    output logic [1:0]               fifo_we,
    output logic [$clog2(DEPTH)-1:0] fifo_widx,
    output logic [AW-1:0]            fifo_wdata,
    output logic [1:0]               fifo_clr,
    output logic [$clog2(DEPTH)-1:0] fifo_clr_idx,
    output logic                     drain_valid,
    output logic                     drain_sel,
    output logic                     act_bank,
    output logic [$clog2(DEPTH):0]   fill_level,
    output logic                     buf_full,
    output logic                     overrun
);
    localparam int DW       = $clog2(DEPTH);
    localparam int SWEEP_N  = sweep_span(AW, DEPTH);
    localparam int SW_W     = $clog2(SWEEP_N);
    localparam logic [DW:0]     FILL_MAX = (DW+1)'(DEPTH);
    localparam logic [SW_W-1:0] SW_LAST  = SW_W'(SWEEP_N - 1);

    seq_state_e    st_q;
    derand_flags_t flg_q;
    logic [AW-1:0]   ev_addr_q;
    logic [SW_W-1:0] sweep_idx;
    logic            act_q;
    logic [DW:0]     wp_q [2];
    logic [DW-1:0]   rp_q;

    logic accept_evt, accept_crd, accept_drn, carry, full_eff, push_ok;

    assign evt_ack    = (st_q == ST_IDLE);
    assign accept_evt = evt_ack && evt_fall && !cmd_init;
    assign accept_crd = evt_ack && !evt_fall && cnt_rd && !cmd_init;
    assign accept_drn = drain_rd && !cmd_drain_rst && !cmd_init;
    assign carry      = (cnt_q == '1);
    // an acknowledgment arriving in the same cycle as a fill counts
    assign full_eff   = flg_q.full && !cmd_drain_rst;
    assign push_ok    = !flg_q.ovr && (wp_q[act_q] < FILL_MAX);

    // counter array port steering
    always_comb begin
        cnt_raddr = (st_q == ST_READ) ? ev_addr_q : cnt_rd_addr;
        cnt_we    = 1'b0;
        cnt_waddr = ev_addr_q;
        cnt_wdata = '0;
        case (st_q)
            ST_SWEEP: begin
                cnt_we    = 1'b1;
                cnt_waddr = sweep_idx[AW-1:0];
            end
            ST_UPD: begin
                cnt_we    = 1'b1;
                cnt_wdata = cnt_q + CW'(1);
            end
            ST_IDLE: begin
                if (accept_crd) begin
                    cnt_we    = 1'b1;
                    cnt_waddr = cnt_rd_addr;
                end
            end
            default: ;
        endcase
    end

    // bank write and clear steering
    always_comb begin
        fifo_we      = 2'b00;
        fifo_widx    = wp_q[act_q][DW-1:0];
        fifo_wdata   = ev_addr_q;
        fifo_clr     = 2'b00;
        fifo_clr_idx = rp_q;
        if (st_q == ST_SWEEP) begin
            fifo_we    = 2'b11;
            fifo_widx  = sweep_idx[DW-1:0];
            fifo_wdata = '0;
        end else if (st_q == ST_PUSH && push_ok) begin
            fifo_we[act_q] = 1'b1;
        end
        if (accept_drn) fifo_clr[drain_bank] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || cmd_init) begin
            st_q        <= ST_SWEEP;
            sweep_idx   <= '0;
            act_q       <= rst ? 1'b0 : init_bank;
            wp_q[0]     <= '0;
            wp_q[1]     <= '0;
            flg_q       <= '0;
            rp_q        <= '0;
            ev_addr_q   <= '0;
            cnt_valid   <= 1'b0;
            drain_valid <= 1'b0;
            drain_sel   <= 1'b0;
        end else begin
            cnt_valid   <= accept_crd;
            drain_valid <= accept_drn;
            if (accept_drn) drain_sel <= drain_bank;

            if (cmd_drain_rst) begin
                rp_q       <= '0;
                flg_q.full <= 1'b0;
            end else if (accept_drn) begin
                rp_q <= rp_q + DW'(1);
            end

            case (st_q)
                ST_SWEEP: begin
                    sweep_idx <= sweep_idx + SW_W'(1);
                    if (sweep_idx == SW_LAST) st_q <= ST_IDLE;
                end
                ST_IDLE: begin
                    if (accept_evt) begin
                        ev_addr_q <= evt_addr;
                        st_q      <= ST_READ;
                    end
                end
                ST_READ: st_q <= ST_UPD;
                ST_UPD:  st_q <= carry ? ST_PUSH : ST_IDLE;
                ST_PUSH: begin
                    st_q <= ST_IDLE;
                    if (push_ok) begin
                        if (wp_q[act_q] == FILL_MAX - (DW+1)'(1)) begin
                            wp_q[act_q] <= FILL_MAX;
                            if (!full_eff) begin
                                act_q        <= ~act_q;
                                wp_q[~act_q] <= '0;
                                flg_q.full   <= 1'b1;
                            end else begin
                                flg_q.ovr <= 1'b1;
                            end
                        end else begin
                            wp_q[act_q] <= wp_q[act_q] + (DW+1)'(1);
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign act_bank   = act_q;
    assign fill_level = wp_q[act_q];
    assign buf_full   = flg_q.full;
    assign overrun    = flg_q.ovr;
endmodule

// File: rtl/ovf_derand_counter.sv
module ovf_derand_counter #(
    parameter int AW    = 8,
    parameter int DEPTH = 16,
    parameter int CW    = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cmd_init,
    input  logic                   init_bank,
    input  logic                   evt_strobe_n,
    input  logic [AW-1:0]          evt_addr,
    output logic                   evt_ack,
    input  logic                   cnt_rd,
    input  logic [AW-1:0]          cnt_rd_addr,
    output logic [CW-1:0]          cnt_data,
    output logic                   cnt_valid,
    input  logic                   drain_rd,
    input  logic                   drain_bank,
    input  logic                   cmd_drain_rst,
    output logic [AW-1:0]          drain_data,
    output logic                   drain_valid,
    output logic                   act_bank,
    output logic [$clog2(DEPTH):0] fill_level,
    output logic                   buf_full,
    output logic                   overrun
);
    localparam int DW = $clog2(DEPTH);

    logic          evt_fall;
    logic [AW-1:0] cnt_raddr, cnt_waddr;
    logic          cnt_we;
    logic [CW-1:0] cnt_wdata;
    logic [1:0]    fifo_we, fifo_clr;
    logic [DW-1:0] fifo_widx, fifo_clr_idx;
    logic [AW-1:0] fifo_wdata;
    logic [AW-1:0] bank_q [2];
    logic          drain_sel;

    ovf_strobe_edge edge_i (
        .clk      (clk),
        .rst      (rst),
        .strobe_n (evt_strobe_n),
        .fall     (evt_fall)
    );

    ovf_cnt_array #(.AW(AW), .CW(CW)) cnt_i (
        .clk     (clk),
        .rd_addr (cnt_raddr),
        .rd_data (cnt_data),
        .we      (cnt_we),
        .wr_addr (cnt_waddr),
        .wr_data (cnt_wdata)
    );

    for (genvar g = 0; g < 2; g++) begin : g_bank
        ovf_fifo_bank #(.DW(DW), .EW(AW)) bank_i (
            .clk     (clk),
            .wr_en   (fifo_we[g]),
            .wr_idx  (fifo_widx),
            .wr_data (fifo_wdata),
            .clr_en  (fifo_clr[g]),
            .clr_idx (fifo_clr_idx),
            .rd_data (bank_q[g])
        );
    end

    ovf_derand_ctrl #(.AW(AW), .DEPTH(DEPTH), .CW(CW)) ctrl_i (
        .clk           (clk),
        .rst           (rst),
        .cmd_init      (cmd_init),
        .init_bank     (init_bank),
        .evt_fall      (evt_fall),
        .evt_addr      (evt_addr),
        .evt_ack       (evt_ack),
        .cnt_rd        (cnt_rd),
        .cnt_rd_addr   (cnt_rd_addr),
        .cnt_q         (cnt_data),
        .cnt_raddr     (cnt_raddr),
        .cnt_we        (cnt_we),
        .cnt_waddr     (cnt_waddr),
        .cnt_wdata     (cnt_wdata),
        .cnt_valid     (cnt_valid),
        .drain_rd      (drain_rd),
        .drain_bank    (drain_bank),
        .cmd_drain_rst (cmd_drain_rst),
        .fifo_we       (fifo_we),
        .fifo_widx     (fifo_widx),
        .fifo_wdata    (fifo_wdata),
        .fifo_clr      (fifo_clr),
        .fifo_clr_idx  (fifo_clr_idx),
        .drain_valid   (drain_valid),
        .drain_sel     (drain_sel),
        .act_bank      (act_bank),
        .fill_level    (fill_level),
        .buf_full      (buf_full),
        .overrun       (overrun)
    );

    assign drain_data = drain_sel ? bank_q[1] : bank_q[0];
endmodule

// File: rtl/ovf_derand_counter_chk.sv
module ovf_derand_counter_chk #(
    parameter int DEPTH = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   cmd_init,
    input logic                   evt_strobe_n,
    input logic                   evt_ack,
    input logic                   cnt_rd,
    input logic                   cnt_valid,
    input logic                   drain_rd,
    input logic                   cmd_drain_rst,
    input logic                   drain_valid,
    input logic                   act_bank,
    input logic [$clog2(DEPTH):0] fill_level,
    input logic                   buf_full,
    input logic                   overrun
);
    localparam logic [$clog2(DEPTH):0] LIMIT = ($clog2(DEPTH)+1)'(DEPTH);

    // R2
    ack_drop_chk: assert property (@(posedge clk) disable iff (rst || cmd_init)
        (evt_ack && $fell(evt_strobe_n)) |=> !evt_ack);

    // R5
    swap_full_chk: assert property (@(posedge clk) disable iff (rst || cmd_init)
        $rose(buf_full) |-> (act_bank != $past(act_bank)));

    // R6
    ovr_hold_chk: assert property (@(posedge clk) disable iff (rst || cmd_init)
        $rose(overrun) |-> $stable(act_bank));

    // R6
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst || cmd_init)
        overrun |=> overrun);

    // R4
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fill_level <= LIMIT);

    // R7
    drain_resp_chk: assert property (@(posedge clk) disable iff (rst || cmd_init)
        (drain_rd && !cmd_drain_rst) |=> drain_valid);

    // R9
    cnt_resp_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_valid |-> $past(cnt_rd && evt_ack));
endmodule

bind ovf_derand_counter ovf_derand_counter_chk #(.DEPTH(DEPTH)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .cmd_init      (cmd_init),
    .evt_strobe_n  (evt_strobe_n),
    .evt_ack       (evt_ack),
    .cnt_rd        (cnt_rd),
    .cnt_valid     (cnt_valid),
    .drain_rd      (drain_rd),
    .cmd_drain_rst (cmd_drain_rst),
    .drain_valid   (drain_valid),
    .act_bank      (act_bank),
    .fill_level    (fill_level),
    .buf_full      (buf_full),
    .overrun       (overrun)
);

// File: tb/ovf_derand_counter_tb_top.sv
`timescale 1ns/1ps
module ovf_derand_counter_tb_top;
    localparam int AW    = 8;
    localparam int DEPTH = 16;
    localparam int CW    = 3;
    localparam int DW    = $clog2(DEPTH);
    localparam int NCNT  = 1 << AW;
    localparam int WRAP  = 1 << CW;
    localparam int SWEEP = (NCNT > DEPTH) ? NCNT : DEPTH;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_init = 1'b0, init_bank = 1'b0;
    logic evt_strobe_n = 1'b1;
    logic [AW-1:0] evt_addr = '0;
    logic evt_ack;
    logic cnt_rd = 1'b0;
    logic [AW-1:0] cnt_rd_addr = '0;
    logic [CW-1:0] cnt_data;
    logic cnt_valid;
    logic drain_rd = 1'b0, drain_bank = 1'b0, cmd_drain_rst = 1'b0;
    logic [AW-1:0] drain_data;
    logic drain_valid, act_bank, buf_full, overrun;
    logic [DW:0] fill_level;

    always #2.5 clk = ~clk;

    ovf_derand_counter #(.AW(AW), .DEPTH(DEPTH), .CW(CW)) dut_i (
        .clk(clk), .rst(rst), .cmd_init(cmd_init), .init_bank(init_bank),
        .evt_strobe_n(evt_strobe_n), .evt_addr(evt_addr), .evt_ack(evt_ack),
        .cnt_rd(cnt_rd), .cnt_rd_addr(cnt_rd_addr), .cnt_data(cnt_data),
        .cnt_valid(cnt_valid), .drain_rd(drain_rd), .drain_bank(drain_bank),
        .cmd_drain_rst(cmd_drain_rst), .drain_data(drain_data),
        .drain_valid(drain_valid), .act_bank(act_bank), .fill_level(fill_level),
        .buf_full(buf_full), .overrun(overrun)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int mc [NCNT];
    int mb [2][DEPTH];
    int mwp [2];
    int mact, mfull, movr, mrp;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_clear(input int bank);
        for (int i = 0; i < NCNT; i++) mc[i] = 0;
        for (int b = 0; b < 2; b++) begin
            for (int i = 0; i < DEPTH; i++) mb[b][i] = 0;
            mwp[b] = 0;
        end
        mact = bank; mfull = 0; movr = 0; mrp = 0;
    endtask

    task automatic model_event(input int a);
        mc[a] = (mc[a] + 1) % WRAP;
        if (mc[a] == 0 && movr == 0) begin
            mb[mact][mwp[mact]] = a;
            mwp[mact]++;
            if (mwp[mact] == DEPTH) begin
                if (mfull == 0) begin
                    mact = 1 - mact;
                    mwp[mact] = 0;
                    mfull = 1;
                end else begin
                    movr = 1;
                end
            end
        end
    endtask

    task automatic wait_ack();
        while (!evt_ack) @(negedge clk);
    endtask

    task automatic send_evt(input int a);
        wait_ack();
        evt_addr = AW'(a);
        evt_strobe_n = 1'b0;
        @(negedge clk);
        chk("R2", "ack low after accepted edge", int'(evt_ack), 0);
        evt_strobe_n = 1'b1;
        wait_ack();
        model_event(a);
    endtask

    task automatic check_flags(input string req);
        chk(req, "act_bank", int'(act_bank), mact);
        chk(req, "buf_full", int'(buf_full), mfull);
        chk(req, "overrun", int'(overrun), movr);
        chk(req, "fill_level", int'(fill_level), mwp[mact]);
    endtask

    task automatic drain_one(input int b, input string req);
        drain_bank = b[0];
        drain_rd = 1'b1;
        @(negedge clk);
        drain_rd = 1'b0;
        chk(req, "drain_valid", int'(drain_valid), 1);
        chk(req, "drain_data", int'(drain_data), mb[b][mrp]);
        mb[b][mrp] = 0;
        mrp = (mrp + 1) % DEPTH;
    endtask

    task automatic drain_reset();
        cmd_drain_rst = 1'b1;
        @(negedge clk);
        cmd_drain_rst = 1'b0;
        mfull = 0; mrp = 0;
        chk("R8", "buf_full after drain reset", int'(buf_full), 0);
    endtask

    task automatic cnt_read(input int a, input string req);
        wait_ack();
        cnt_rd_addr = AW'(a);
        cnt_rd = 1'b1;
        @(negedge clk);
        cnt_rd = 1'b0;
        chk(req, "cnt_valid", int'(cnt_valid), 1);
        chk(req, "cnt_data", int'(cnt_data), mc[a]);
        mc[a] = 0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog expired actual 0 expected 1");
            finish_run();
        end
    end

    initial begin
        int picks [6];
        int guard;
        int cyc;
        picks = '{1, 2, 3, 4, 6, 7};
        void'($urandom(32'd20240));
        model_clear(0);

        // R1: reset sweep
        repeat (4) @(negedge clk);
        rst = 1'b0;
        chk("R1", "ack low during sweep", int'(evt_ack), 0);
        cyc = 0;
        while (!evt_ack && cyc < 2 * SWEEP) begin
            @(negedge clk);
            cyc++;
        end
        chk("R1", "sweep length", cyc, SWEEP);
        check_flags("R1");

        // R2 / R4: eight events on one pixel give one push
        for (int i = 0; i < WRAP; i++) send_evt(5);
        check_flags("R4");
        cnt_read(5, "R4");

        // R9: readback and clear
        for (int i = 0; i < 3; i++) send_evt(9);
        cnt_read(9, "R9");
        cnt_read(9, "R9");

        // R3: edge while busy is ignored
        wait_ack();
        evt_addr = AW'(20);
        evt_strobe_n = 1'b0;
        @(negedge clk);
        evt_strobe_n = 1'b1;
        @(negedge clk);
        evt_strobe_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        evt_strobe_n = 1'b1;
        @(negedge clk);
        model_event(20);
        cnt_read(20, "R3");

        // R5: random events until the first swap
        guard = 0;
        while (mfull == 0 && guard < 3000) begin
            send_evt(picks[$urandom % 6]);
            check_flags("R5");
            guard++;
        end
        chk("R5", "swapped to bank 1", int'(act_bank), 1);

        // R8: drain reset wins over a same-cycle drain read
        cmd_drain_rst = 1'b1;
        drain_rd = 1'b1;
        drain_bank = 1'b0;
        @(negedge clk);
        cmd_drain_rst = 1'b0;
        drain_rd = 1'b0;
        mfull = 0; mrp = 0;
        chk("R8", "buf_full cleared", int'(buf_full), 0);
        chk("R8", "no drain_valid", int'(drain_valid), 0);

        // R7: empty the filled bank, then confirm clear-on-read
        for (int i = 0; i < DEPTH; i++) drain_one(0, "R7");
        drain_one(0, "R7");
        drain_one(0, "R7");
        drain_reset();

        // R6: second swap sets full, third fill without acknowledgment overruns
        guard = 0;
        while (movr == 0 && guard < 6000) begin
            send_evt(picks[$urandom % 6]);
            check_flags("R6");
            guard++;
        end
        chk("R6", "overrun reached", movr, 1);
        for (int i = 0; i < 2 * WRAP; i++) send_evt(11);
        check_flags("R6");
        cnt_read(11, "R6");

        // R1: init command with bank 1
        init_bank = 1'b1;
        cmd_init = 1'b1;
        @(negedge clk);
        cmd_init = 1'b0;
        model_clear(1);
        chk("R1", "ack low after init", int'(evt_ack), 0);
        wait_ack();
        check_flags("R1");
        cnt_read(1, "R1");

        // R7: draining the collecting bank at end of acquisition
        for (int i = 0; i < WRAP; i++) send_evt(3);
        check_flags("R4");
        drain_reset();
        drain_one(1, "R7");
        drain_one(1, "R7");

        done = 1'b1;
        finish_run();
    end
endmodule